// File: doc/BRIEF.md
# Banked Auto-Increment Read Prefetch Port

This block is the slave-side address logic of a host bus that reaches an internal buffer memory and a small register file. Each cycle carries at most one single-cycle strobe, either a read or a write, with an 18-bit address. Bits [17:16] of the address are the bank-select field. Bits [15:0] are a byte address.

Software picks a bank and a start address by writing the control register. From then on, every read in that bank fetches the word at that bank's own read pointer and advances the pointer. The low address lines are ignored for such reads. The pointers are independent, so a host can interleave several streams and each resumes where it stopped. Memory writes, register accesses and reads with bank select 00 use the bus address directly and never move a pointer.

Read data comes from a synchronous RAM and is registered, so it appears one cycle after the strobe, together with a valid pulse.

Top module: `bank_prefetch_port`

## Requirements
- R1: After reset, every bank pointer is zero, `bus_rdata` is zero and `bus_rvalid` is low. Each register-file entry and the control register read back as zero.
- R2: A write with bank select 00 to byte address 0x003C is a control write, and it loads one bank pointer. Data bits [17:16] name the bank (1 to 3). Data bits [15:0] give the start byte address, with bits [1:0] forced to zero. A read of 0x003C returns {bank, aligned start} in bits [17:0], with zeros above. A control write naming bank 0 loads no pointer.
- R3: A read with bank select b ≠ 00 returns the memory word at bank b's pointer, whatever `bus_addr[15:0]` carries. Memory word index is byte address bits [9:2].
- R4: Each read in bank b advances pointer b by 4, wrapping modulo 2^16. Four reads after loading 0x4100 fetch 0x4100, 0x4104, 0x4108 and 0x410C.
- R5: A read in one bank leaves the other pointers unchanged, so each bank resumes at the word after its last fetch.
- R6: A write to byte address A with A[15:10] ≠ 0 stores the data at memory word A[9:2]. The write ignores bits [17:16] and changes no pointer.
- R7: A read with bank select 00 and A[15:10] ≠ 0 returns memory word A[9:2] directly and changes no pointer.
- R8: Addresses with A[15:10] = 0, other than the control register, reach an 8-entry register file indexed by A[4:2]. Reads and writes there need no pointer setup and change no pointer.
- R9: Read data and a one-cycle `bus_rvalid` pulse appear in the cycle after every read strobe. `bus_rvalid` stays low after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 18 | Bank select [17:16] and byte address [15:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |

## Verification
On every cycle, the assertions check the following pointer and strobe rules:
- A read in a bank moves that bank's pointer by exactly 4.
- A bank that is neither read nor loaded keeps its pointer.
- A control write loads the aligned start address.
- Pointers stay word aligned.
- The valid pulse follows each read strobe.

Only the bench scenarios show that the returned data is the right memory word. These include fetches from the pointer while the low address is ignored, interleaved banks that resume correctly, wrap at the top of the address range, and the direct paths for bank 00 and for the register file.

// File: rtl/bank_prefetch_port.sv
module bank_prefetch_port #(
  parameter int DATA_W    = 32,
  parameter int PTR_W     = 16,
  parameter int SEL_W     = 2,
  parameter int RAM_AW    = 8,
  parameter int REG_AW    = 3,
  parameter int SPACE_LSB = 10,
  parameter int CTRL_IDX  = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [PTR_W+SEL_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid
);
  localparam int ADDR_W = PTR_W + SEL_W;
  localparam int NBANK  = 1 << SEL_W;
  localparam int RAM_D  = 1 << RAM_AW;
  localparam int REG_D  = 1 << REG_AW;
  localparam int IDX_W  = SPACE_LSB - 2;

  wire [SEL_W-1:0] sel    = bus_addr[ADDR_W-1:PTR_W];
  wire [PTR_W-1:0] low    = bus_addr[PTR_W-1:0];
  wire             is_mem = |low[PTR_W-1:SPACE_LSB];
  wire             is_ctl = !is_mem && (low[SPACE_LSB-1:2] == IDX_W'(CTRL_IDX));
  wire             pf_rd  = bus_rd && (sel != '0);
  wire             ctl_wr = bus_wr && is_ctl;
  wire [SEL_W-1:0] ld_sel = bus_wdata[ADDR_W-1:PTR_W];
  wire [PTR_W-1:0] ld_val = {bus_wdata[PTR_W-1:2], 2'b00};

  logic [PTR_W-1:0]  ptr_q [NBANK];
  logic [DATA_W-1:0] ram   [RAM_D];
  logic [DATA_W-1:0] regs  [REG_D];
  logic [DATA_W-1:0] ctl_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b == 0) begin : g_direct
      always_ff @(posedge clk) ptr_q[b] <= '0;
    end else begin : g_ptr
      always_ff @(posedge clk) begin
        if (!rst_n)                                ptr_q[b] <= '0;
        else if (ctl_wr && ld_sel == SEL_W'(b))    ptr_q[b] <= ld_val;
        else if (pf_rd && sel == SEL_W'(b))        ptr_q[b] <= ptr_q[b] + PTR_W'(4);
      end

      // R4
      adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_rd && sel == SEL_W'(b) && !bus_wr) |=> ptr_q[b] == $past(ptr_q[b]) + PTR_W'(4));
      // R5
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_rd && sel == SEL_W'(b)) && !(ctl_wr && ld_sel == SEL_W'(b))) |=> $stable(ptr_q[b]));
      // R2
      load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ld_sel == SEL_W'(b)) |=> ptr_q[b] == {$past(bus_wdata[PTR_W-1:2]), 2'b00});
      // R4
      align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[b][1:0] == 2'b00);
    end
  end

  wire [PTR_W-1:0]  cur_ptr = ptr_q[sel];
  wire [RAM_AW-1:0] rd_idx  = pf_rd ? cur_ptr[RAM_AW+1:2] : low[RAM_AW+1:2];
  wire [REG_AW-1:0] reg_idx = low[REG_AW+1:2];

  always_ff @(posedge clk)
    if (bus_wr && is_mem) ram[low[RAM_AW+1:2]] <= bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_D; i++) regs[i] <= '0;
      ctl_q <= '0;
    end else if (bus_wr && !is_mem) begin
      if (is_ctl) ctl_q <= DATA_W'({ld_sel, ld_val});
      else        regs[reg_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (pf_rd || is_mem) bus_rdata <= ram[rd_idx];
        else if (is_ctl)     bus_rdata <= ctl_q;
        else                 bus_rdata <= regs[reg_idx];
      end
    end
  end

  // R9
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  // R9
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  // R1
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/bank_prefetch_port_tb.sv
module bank_prefetch_port_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [17:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] model [256];

  bank_prefetch_port u_dut (.clk, .rst_n, .bus_rd, .bus_wr, .bus_addr,
                            .bus_wdata, .bus_rdata, .bus_rvalid);

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [17:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [17:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    check("R9 rvalid", {31'b0, bus_rvalid}, 1);
    d = bus_rdata;
    @(negedge clk);
    check("R9 rvalid idle", {31'b0, bus_rvalid}, 0);
  endtask

  task automatic load(logic [1:0] b, logic [15:0] s);
    wr(18'h0003C, {14'b0, b, s});
  endtask

  function automatic logic [31:0] mword(logic [15:0] p);
    return model[p[9:2]];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rvalid", {31'b0, bus_rvalid}, 0);
    check("R1 rdata", bus_rdata, 0);
    rd(18'h0003C, d); check("R1 ctrl", d, 0);
    rd(18'h00008, d); check("R1 reg", d, 0);
  endtask

  task automatic t_fill;
    logic [31:0] d;
    for (int i = 0; i < 256; i++) begin
      model[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
      wr({2'b11, 16'h0400} + 18'(i * 4), model[i]);
    end
    rd(18'h00400 + 18'(17 * 4), d); check("R6/R7 direct", d, model[17]);
  endtask

  task automatic t_pointers;
    logic [31:0] d;
    rd(18'h1_0000, d); check("R1 bank1 at zero", d, model[0]);
    load(2'b10, 16'h4102);
    rd(18'h0003C, d); check("R2 ctrl readback", d, {14'b0, 2'b10, 16'h4100});
    for (int k = 0; k < 4; k++) begin
      rd({2'b10, 16'(k * 16'h1234)}, d);
      check("R3/R4 bank2 seq", d, mword(16'h4100 + 16'(4 * k)));
    end
    load(2'b01, 16'h4000);
    for (int k = 0; k < 4; k++) begin
      rd(18'h1_0000, d); check("R4 bank1 seq", d, mword(16'h4000 + 16'(4 * k)));
    end
    rd(18'h2_0000, d); check("R5 bank2 resumes", d, mword(16'h4110));
    rd(18'h1_0000, d); check("R5 bank1 resumes", d, mword(16'h4010));
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    load(2'b11, 16'hFFFC);
    rd(18'h3_1234, d); check("R4 before wrap", d, mword(16'hFFFC));
    rd(18'h3_0000, d); check("R4 after wrap", d, mword(16'h0000));
    load(2'b00, 16'h8000);
    rd(18'h3_0000, d); check("R2 bank0 load ignored", d, mword(16'h0004));
  endtask

  task automatic t_direct;
    logic [31:0] d;
    wr(18'h1_0800, 32'hDEAD_BEEF); model[8'h00] = 32'hDEAD_BEEF;
    rd(18'h00400, d); check("R6 write no incr", d, 32'hDEAD_BEEF);
    rd(18'h00404, d); check("R7 bank0 read", d, model[1]);
    rd(18'h2_0000, d); check("R6/R7 bank2 unmoved", d, mword(16'h4114));
    wr(18'h00008, 32'h1111_2222);
    wr(18'h00014, 32'h3333_4444);
    rd(18'h00008, d); check("R8 reg2", d, 32'h1111_2222);
    rd(18'h00014, d); check("R8 reg5", d, 32'h3333_4444);
    rd(18'h00028, d); check("R8 alias reg2", d, 32'h1111_2222);
    rd(18'h1_0000, d); check("R8 bank1 unmoved", d, mword(16'h4014));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_fill;
    t_pointers;
    t_wrap;
    t_direct;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule